// File: doc/BRIEF.md
# Asynchronous ROM Read Controller

This block sits between a clocked host and an asynchronous parallel mask ROM that can be read either sixteen bits or eight bits at a time. The host offers a read as a byte address plus a width flag on a valid/ready handshake. The controller then drives the ROM address, the active-low chip and output enables, and the width-select line. In byte mode it also drives the shared least-significant address line. It waits out the ROM access limits, captures the data and returns it with a one-cycle response pulse.

Every ROM timing figure is a nanosecond parameter. The controller turns each one into a clock count, rounding up, using a clock-period parameter. Three separate counters track the address, chip-enable and output-enable access limits. The data is captured one extra cycle after the last of the three counters runs out, which leaves a margin.

After each read the enables are released. Ready then stays low long enough for the ROM outputs to float and for the minimum read-cycle time to pass before the next address can appear.

Top module: `romRdTop`

## Requirements
- R1: Reset state:
  - ready is high;
  - both enables are high (inactive);
  - the response pulse is low.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready is low from the next cycle until recovery ends.
- R3: The address, the chip enable (low) and the output enable (low) are all driven in the first cycle after a request is taken.
- R4: With A, C and O as the rounded-up cycle counts of the three access limits, the response pulse comes exactly max(A,C,O)+1 cycles after the accepting edge.
- R5: The ROM address and the least-significant line stay steady while the chip enable is low.
- R6: The response pulse lasts one cycle. Both enables go high on the same edge that raises it.
- R7: Once the enables have been released, they stay high for at least the float-recovery count before the next read.
- R8: Ready comes back max(F, RC-N, 1) cycles after the response, where F is the float count, RC the cycle-time count and N the sampling delay from R4. As a result, successive ROM address changes are at least RC cycles apart.
- R9: Word mode (width flag 0):
  - width-select is driven 1;
  - the shared line is not driven;
  - the 19-bit ROM address is request address bits [19:1], and bit 0 is ignored;
  - all 16 data bits are returned.
- R10: Byte mode (width flag 1):
  - width-select is driven 0;
  - the shared line is driven with request bit 0;
  - the response is ROM data bits [7:0] zero-extended to 16 bits.
- R11: Request address, width and valid are ignored while ready is low. The ROM address and the returned data always belong to the request that was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request offered |
| reqReady | output | 1 | Controller can take a request |
| reqAddr | input | 20 | Byte address of the read |
| reqByte | input | 1 | 1 = byte read, 0 = word read |
| rspValid | output | 1 | One-cycle pulse: rspData holds the result |
| rspData | output | 16 | Returned data (byte reads zero-extended) |
| romAddr | output | 19 | ROM address lines |
| romCeN | output | 1 | ROM chip enable, active low |
| romOeN | output | 1 | ROM output enable, active low |
| romWordSel | output | 1 | ROM width select, 1 = word |
| romLsbOut | output | 1 | Value for the shared data/address line in byte mode |
| romLsbEn | output | 1 | Drive enable for the shared line |
| romData | input | 16 | ROM data outputs |

## Verification
The bench ROM model returns a garbage pattern until every access limit has passed since the last address, chip-enable and output-enable change. A controller that sampled before the slowest limit would therefore return garbage, and a missing margin cycle would show up as a response one cycle early.

The model also measures:
- the spacing between address changes, which a short recovery count would break;
- the enable-high gap before the next read, which a missing float wait would cut short.

Byte reads at both values of the low address bit check that the shared line is driven and that the upper byte is cleared; a design that leaked the ROM's floating upper bits would return 0xA5 there. Garbage addresses offered while the controller is busy would change the address or the data of a design that took requests without ready.

// File: rtl/romRdPkg.sv
package romRdPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_SETTLE,
    ST_RECOVER
  } rdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // request accepted this cycle
    logic sample;  // capture ROM data this cycle
  } rdStrobe_t;

  function automatic int ns2cyc(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/romRdCtrl.sv
module romRdCtrl
  import romRdPkg::*;
#(
  parameter int AA_CYC = 10,
  parameter int CE_CYC = 10,
  parameter int OE_CYC = 5,
  parameter int RC_CYC = 10,
  parameter int DF_CYC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      romCeN,
  output logic      romOeN,
  output logic      rspValid,
  output rdStrobe_t strobe
);

  localparam int NLIM    = 3;
  localparam int LIM [NLIM] = '{AA_CYC, CE_CYC, OE_CYC};
  localparam int MAX_ACC = maxOf(maxOf(AA_CYC, CE_CYC), OE_CYC);
  localparam int SAMP_N  = MAX_ACC + 1;
  localparam int REC_CYC = maxOf(maxOf(DF_CYC, RC_CYC - SAMP_N), 1);
  localparam int CNT_W   = $clog2(maxOf(MAX_ACC, REC_CYC) + 2);
  localparam int AGE_W   = $clog2(SAMP_N + REC_CYC + 2);

  rdState_e          st;
  logic [NLIM-1:0]   limDone;
  logic [CNT_W-1:0]  recCnt;

  assign reqReady      = (st == ST_IDLE);
  assign strobe.load   = (st == ST_IDLE) && reqValid;
  assign strobe.sample = (st == ST_SETTLE);

  // one wait counter per access limit
  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN)                cnt <= '0;
      else if (strobe.load)     cnt <= CNT_W'(LIM[g] - 1);
      else if (cnt != '0)       cnt <= cnt - 1'b1;
    end
    assign limDone[g] = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      romCeN   <= 1'b1;
      romOeN   <= 1'b1;
      rspValid <= 1'b0;
      recCnt   <= '0;
    end else begin
      rspValid <= 1'b0;
      unique case (st)
        ST_IDLE: if (reqValid) begin
          st     <= ST_ACCESS;
          romCeN <= 1'b0;
          romOeN <= 1'b0;
        end
        ST_ACCESS: if (&limDone) st <= ST_SETTLE;
        ST_SETTLE: begin
          rspValid <= 1'b1;
          romCeN   <= 1'b1;
          romOeN   <= 1'b1;
          recCnt   <= CNT_W'(REC_CYC - 1);
          st       <= ST_RECOVER;
        end
        ST_RECOVER: begin
          if (recCnt == '0) st <= ST_IDLE;
          else              recCnt <= recCnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // assertion support: cycles since the accepting edge
  logic [AGE_W-1:0] accAge;
  always_ff @(posedge clk) begin
    if (!rstN)                               accAge <= '0;
    else if (strobe.load)                    accAge <= '0;
    else if (accAge != {AGE_W{1'b1}})        accAge <= accAge + 1'b1;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r3_enables_together: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!romCeN && !romOeN));

  a_r4_sample_point: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (accAge == AGE_W'(SAMP_N)));

  a_r6_release_with_resp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (romCeN && romOeN));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/romRdPath.sv
module romRdPath
  import romRdPkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqByte,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romWordSel,
  output logic              romLsbOut,
  output logic              romLsbEn,
  output logic [DATA_W-1:0] rspData
);

  localparam int BYTE_W = DATA_W / 2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romAddr    <= '0;
      romWordSel <= 1'b1;
      romLsbOut  <= 1'b0;
      romLsbEn   <= 1'b0;
    end else if (strobe.load) begin
      romAddr    <= reqAddr[ADDR_W:1];
      romWordSel <= !reqByte;
      romLsbOut  <= reqByte & reqAddr[0];
      romLsbEn   <= reqByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rspData <= '0;
    else if (strobe.sample)
      rspData <= romWordSel ? romData
                            : {{(DATA_W-BYTE_W){1'b0}}, romData[BYTE_W-1:0]};
  end

  a_r9_word_full: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && romWordSel) |=> (rspData == $past(romData)));

  a_r10_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && !romWordSel) |=> (rspData[DATA_W-1:BYTE_W] == '0));

endmodule

// File: rtl/romRdTop.sv
module romRdTop
  import romRdPkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AA_NS       = 100,
  parameter int T_CE_NS       = 100,
  parameter int T_OE_NS       = 50,
  parameter int T_RC_NS       = 100,
  parameter int T_DF_NS       = 20,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqByte,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  output logic              romWordSel,
  output logic              romLsbOut,
  output logic              romLsbEn,
  input  logic [DATA_W-1:0] romData
);

  localparam int AA_CYC = ns2cyc(T_AA_NS, CLK_PERIOD_NS);
  localparam int CE_CYC = ns2cyc(T_CE_NS, CLK_PERIOD_NS);
  localparam int OE_CYC = ns2cyc(T_OE_NS, CLK_PERIOD_NS);
  localparam int RC_CYC = ns2cyc(T_RC_NS, CLK_PERIOD_NS);
  localparam int DF_CYC = ns2cyc(T_DF_NS, CLK_PERIOD_NS);

  rdStrobe_t strobe;

  romRdCtrl #(
    .AA_CYC(AA_CYC), .CE_CYC(CE_CYC), .OE_CYC(OE_CYC),
    .RC_CYC(RC_CYC), .DF_CYC(DF_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .romCeN(romCeN), .romOeN(romOeN), .rspValid(rspValid), .strobe(strobe)
  );

  romRdPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqByte(reqByte), .romData(romData), .romAddr(romAddr),
    .romWordSel(romWordSel), .romLsbOut(romLsbOut), .romLsbEn(romLsbEn),
    .rspData(rspData)
  );

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && $past(!romCeN)) |-> ($stable(romAddr) && $stable(romLsbOut)));

endmodule

// File: tb/test_romRdTop.sv
module test_romRdTop;

  localparam int CLK_NS = 10;
  localparam int AA_NS = 95, CE_NS = 120, OE_NS = 50, RC_NS = 250, DF_NS = 30;
  localparam int AA_C = (AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int CE_C = (CE_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_C = (OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int RC_C = (RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int DF_C = (DF_NS + CLK_NS - 1) / CLK_NS;
  localparam int M_C  = (AA_C > CE_C ? (AA_C > OE_C ? AA_C : OE_C) : (CE_C > OE_C ? CE_C : OE_C));
  localparam int N_C  = M_C + 1;
  localparam int G0   = (DF_C > RC_C - N_C) ? DF_C : RC_C - N_C;
  localparam int G_C  = (G0 < 1) ? 1 : G0;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqByte = 1'b0;
  logic [19:0] reqAddr = '0;
  logic reqReady, rspValid, romCeN, romOeN, romWordSel, romLsbOut, romLsbEn;
  logic [15:0] rspData, romData;
  logic [18:0] romAddr;

  romRdTop #(
    .CLK_PERIOD_NS(CLK_NS), .T_AA_NS(AA_NS), .T_CE_NS(CE_NS),
    .T_OE_NS(OE_NS), .T_RC_NS(RC_NS), .T_DF_NS(DF_NS)
  ) i_romRdTop (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqByte(reqByte), .rspValid(rspValid),
    .rspData(rspData), .romAddr(romAddr), .romCeN(romCeN), .romOeN(romOeN),
    .romWordSel(romWordSel), .romLsbOut(romLsbOut), .romLsbEn(romLsbEn),
    .romData(romData)
  );

  always #(CLK_NS/2) clk = ~clk;

  int vectors = 0, fails = 0;
  bit live = 1'b0, done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] romWord(input logic [18:0] w);
    logic [31:0] p;
    p = {13'b0, w} * 32'd40503;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] expRsp(input logic [19:0] a, input logic b);
    logic [15:0] w;
    w = romWord(a[19:1]);
    if (!b) return w;
    return {8'h00, a[0] ? w[15:8] : w[7:0]};
  endfunction

  // reference model, advanced on every rising edge
  int age = -1;
  logic [19:0] capA = '0;
  logic capB = 1'b0;
  always @(posedge clk) begin
    if (!rstN) age = -1;
    else if (age < 0) begin
      if (reqValid) begin age = 0; capA = reqAddr; capB = reqByte; end
    end else begin
      age++;
      if (age == N_C + G_C) age = -1;
    end
  end

  // ROM model with access timing, plus per-cycle comparison
  logic [19:0] pAddr = '0;
  logic pCe = 1'b1, pOe = 1'b1;
  int cyc = 0, aAge = 0, cAge = 0, oAge = 0, lastAddr = 0, ceRise = 0;
  bit seenAddr = 1'b0, seenRise = 1'b0;
  always @(negedge clk) begin
    logic [19:0] curA;
    logic [15:0] w;
    cyc++;
    curA = {romAddr, romLsbEn & romLsbOut};
    if (live && curA !== pAddr) begin
      if (seenAddr) chk("R8 address spacing", 32'(cyc - lastAddr >= RC_C), 1);
      seenAddr = 1'b1; lastAddr = cyc; aAge = 0;
    end else aAge++;
    if (pCe && !romCeN) begin
      if (seenRise) chk("R7 float gap", 32'(cyc - ceRise >= DF_C), 1);
      cAge = 0;
    end else cAge++;
    if (!pCe && romCeN) begin ceRise = cyc; seenRise = 1'b1; end
    if (pOe && !romOeN) oAge = 0; else oAge++;
    pAddr = curA; pCe = romCeN; pOe = romOeN;
    w = romWord(romAddr);
    if (!romCeN && !romOeN && aAge >= AA_C && cAge >= CE_C && oAge >= OE_C)
      romData = romWordSel ? w : {8'hA5, (romLsbEn && romLsbOut) ? w[15:8] : w[7:0]};
    else
      romData = 16'hDEAD;

    if (live && !done) begin
      chk("R2 ready", 32'(reqReady), 32'(age < 0));
      chk("R3 chip enable", 32'(romCeN), 32'(!(age >= 0 && age < N_C)));
      chk("R3 output enable", 32'(romOeN), 32'(!(age >= 0 && age < N_C)));
      chk("R4 R6 response pulse", 32'(rspValid), 32'(age == N_C));
      if (age == N_C)
        chk(capB ? "R10 byte data" : "R9 word data", 32'(rspData), 32'(expRsp(capA, capB)));
      if (age >= 0 && age < N_C) begin
        chk("R5 R11 rom address", 32'(romAddr), 32'(capA[19:1]));
        chk("R9 R10 width select", 32'(romWordSel), 32'(!capB));
        chk("R9 R10 shared line enable", 32'(romLsbEn), 32'(capB));
        if (capB) chk("R10 shared line value", 32'(romLsbOut), 32'(capA[0]));
      end
    end
  end

  task automatic rd(input logic [19:0] a, input logic b, input bit noise);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqByte = b;
    @(negedge clk);
    if (noise) begin
      reqValid = 1'b1; reqAddr = 20'($urandom); reqByte = 1'($urandom);
    end else reqValid = 1'b0;
  endtask

  task automatic finishRun;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready at reset", 32'(reqReady), 1);
    chk("R1 ce at reset", 32'(romCeN), 1);
    chk("R1 oe at reset", 32'(romOeN), 1);
    chk("R1 resp at reset", 32'(rspValid), 0);
    rstN = 1'b1;
    live = 1'b1;
    rd(20'h00000, 1'b0, 1'b0);
    rd(20'h00001, 1'b0, 1'b0);   // R9: bit 0 ignored in word mode
    rd(20'h12345, 1'b1, 1'b1);   // R10 high byte, R11 noise while busy
    rd(20'h12344, 1'b1, 1'b0);   // R10 low byte
    rd(20'hFFFFF, 1'b0, 1'b1);
    rd(20'hFFFFF, 1'b1, 1'b0);
    rd(20'hFFFFE, 1'b1, 1'b0);
    for (int i = 0; i < 24; i++) rd(20'($urandom), 1'($urandom), 1'($urandom));
    rd(20'h0ABCD, 1'b0, 1'b0);
    repeat (N_C + G_C + 6) @(negedge clk);
    finishRun();
  end

endmodule